// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block gathers every reset request in the chip and turns the winning request into a single system reset pulse. It also keeps a small status word that tells software why the last reset happened. The requests are:

- a pin reset and two supply brown-out detectors;
- a thermal-shutdown comparator and a slow-clock loss detector;
- the watchdog, CPU lockup, CPU reset request and debug reset;
- an analog state-machine timeout, plus analog and digital error events;
- a software request made through a three-bit control write port.

The block's own synchronous reset stands for power-on. It clears the status word and the control bits.

The status word holds a two-level cause. A primary class says whether the last reset came from power-on, the pin, a supply loss or the digital system reset. For a system reset, a sub-source code names the system event that caused it. A separate flag marks a thermal shutdown, which is logged as a pin reset. The thermal source and the clock-loss source only act when their enable bits in the control register are set. Once a reset pulse has started, requests are not sampled again until the pulse has ended.

Top module: `rst_cause_ctl`

## Requirements
- R1: `status_o[2:0]` holds the primary class. The codes are 0 for power-on, 1 for pin reset, 2 for main-supply brown-out, 4 for core-supply brown-out and 6 for digital system reset.
- R2: `status_o[7:4]` holds the sub-source code when the class is 6. The codes are clock loss 0, CPU reset 1, CPU lockup 2, watchdog 3, software 4, debug 5, analog FSM timeout 6, analog error 14 and digital error 15. For any other class the field is 0.
- R3: When several requests are active in the same cycle, exactly one cause is recorded. The priority, highest first, is: main-supply loss, core-supply loss, thermal, pin, then system sources by decreasing sub-source code.
- R4: A control write with bit 0 set starts a system reset with sub-source 4. A write with bit 0 clear starts no reset and leaves the status unchanged.
- R5: Control bit 2 arms the clock-loss source. When armed, clock loss gives class 6 with sub-source 0. When disarmed, clock loss is ignored.
- R6: Control bit 1 enables the thermal source. A thermal event is then logged as class 1 with `status_o[3]` set. The reset output stays high until the thermal input falls, but never for fewer cycles than the pulse length. With the enable clear, the thermal input is ignored.
- R7: With parameter `TSD_PRESENT` at 0, the thermal input never causes a reset, even when control bit 1 is set.
- R8: `sys_rst_o` goes high on the clock edge after a request is seen and stays high for exactly `PULSE_LEN` cycles (default 8) unless thermal hold applies. The status word is updated on the same edge on which `sys_rst_o` rises.
- R9: Power-on (`rst`) clears the whole status word to 0 and both enable bits to 0. A system-generated reset changes only the status word and leaves the enable bits as they were.
- R10: Requests that arrive while `sys_rst_o` is high are dropped. They neither extend the pulse nor start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_rst_i | input | 1 | External pin reset request |
| main_bod_i | input | 1 | Main-supply brown-out detect |
| core_bod_i | input | 1 | Core-supply brown-out detect |
| tsd_i | input | 1 | Thermal-shutdown comparator |
| clk_loss_i | input | 1 | Slow-clock loss detect |
| cpu_rst_req_i | input | 1 | CPU reset request |
| lockup_i | input | 1 | CPU lockup event |
| wdog_i | input | 1 | Watchdog timeout |
| dbg_rst_i | input | 1 | Debug reset request |
| afsm_tmo_i | input | 1 | Analog state-machine timeout |
| ana_err_i | input | 1 | Analog error event |
| dig_err_i | input | 1 | Digital error event |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control write data: bit 0 software reset, bit 1 thermal enable, bit 2 clock-loss arm |
| sys_rst_o | output | 1 | System reset pulse |
| status_o | output | 8 | Last-cause status word |

## Verification
A wrong arbitration or encoding shows up in `status_o` on the very edge on which `sys_rst_o` rises. The bench therefore compares the status word on the first cycle of each pulse, and it also measures the pulse length. A stuck sequencer or a lost thermal hold shows as a pulse that is too short or too long, which is visible only when the pulse falls. An enable bit that is wrongly cleared or wrongly set stays hidden until the gated source fires. For that reason, each enable is probed with a request after every change that could disturb it.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int NUM_SYS       = 9;
    localparam int CTRL_W        = 3;
    localparam int CTRL_SOFT_BIT = 0;
    localparam int CTRL_TSD_BIT  = 1;
    localparam int CTRL_LFL_BIT  = 2;

    typedef enum logic [2:0] {
        CLS_PWRON    = 3'd0,
        CLS_PIN      = 3'd1,
        CLS_MAIN_BOD = 3'd2,
        CLS_CORE_BOD = 3'd4,
        CLS_SYSTEM   = 3'd6
    } cls_e;

    typedef enum logic [3:0] {
        SUB_CLKLOSS = 4'd0,
        SUB_CPURST  = 4'd1,
        SUB_LOCKUP  = 4'd2,
        SUB_WDOG    = 4'd3,
        SUB_SOFT    = 4'd4,
        SUB_DEBUG   = 4'd5,
        SUB_AFSM    = 4'd6,
        SUB_AERR    = 4'd14,
        SUB_DERR    = 4'd15
    } sub_e;

    typedef struct packed {
        sub_e sub;
        logic thermal;
        cls_e cls;
    } cause_t;

    typedef enum logic { SEQ_IDLE = 1'b0, SEQ_ACTIVE = 1'b1 } seq_e;

    localparam int STATUS_W = $bits(cause_t);

    localparam cause_t CAUSE_CLEAR = '{sub: SUB_CLKLOSS, thermal: 1'b0, cls: CLS_PWRON};

    // System request vector index -> sub-source code; index order matches
    // increasing code, so a higher index has higher priority.
    function automatic sub_e sys_code(input int idx);
        case (idx)
            0:       return SUB_CLKLOSS;
            1:       return SUB_CPURST;
            2:       return SUB_LOCKUP;
            3:       return SUB_WDOG;
            4:       return SUB_SOFT;
            5:       return SUB_DEBUG;
            6:       return SUB_AFSM;
            7:       return SUB_AERR;
            default: return SUB_DERR;
        endcase
    endfunction

endpackage

// File: rtl/rcc_ctrl_reg.sv
module rcc_ctrl_reg
    import rcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              soft_req,
    output logic              tsd_en,
    output logic              lfl_arm
);

    logic tsd_en_q;
    logic lfl_arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsd_en_q  <= 1'b0;
            lfl_arm_q <= 1'b0;
        end else if (wr_en) begin
            tsd_en_q  <= wr_data[CTRL_TSD_BIT];
            lfl_arm_q <= wr_data[CTRL_LFL_BIT];
        end
    end

    assign soft_req = wr_en & wr_data[CTRL_SOFT_BIT];
    assign tsd_en   = tsd_en_q;
    assign lfl_arm  = lfl_arm_q;

    AST_ARM_KEPT: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(lfl_arm) && $stable(tsd_en)); // R9

endmodule

// File: rtl/rcc_arbiter.sv
module rcc_arbiter
    import rcc_pkg::*;
#(
    parameter bit TSD_PRESENT = 1'b1
) (
    input  logic               main_bod,
    input  logic               core_bod,
    input  logic               pin_req,
    input  logic               tsd_raw,
    input  logic               tsd_en,
    input  logic [NUM_SYS-1:0] sys_req,
    output logic               tsd_live,
    output logic               any_req,
    output cause_t             cause
);

    generate
        if (TSD_PRESENT) begin : g_tsd
            assign tsd_live = tsd_raw & tsd_en;
        end else begin : g_no_tsd
            assign tsd_live = 1'b0;
        end
    endgenerate

    // Later assignments override earlier ones: lowest priority first.
    always_comb begin
        cause   = CAUSE_CLEAR;
        any_req = 1'b0;
        for (int i = 0; i < NUM_SYS; i++) begin
            if (sys_req[i]) begin
                cause   = '{sub: sys_code(i), thermal: 1'b0, cls: CLS_SYSTEM};
                any_req = 1'b1;
            end
        end
        if (pin_req) begin
            cause   = '{sub: SUB_CLKLOSS, thermal: 1'b0, cls: CLS_PIN};
            any_req = 1'b1;
        end
        if (tsd_live) begin
            cause   = '{sub: SUB_CLKLOSS, thermal: 1'b1, cls: CLS_PIN};
            any_req = 1'b1;
        end
        if (core_bod) begin
            cause   = '{sub: SUB_CLKLOSS, thermal: 1'b0, cls: CLS_CORE_BOD};
            any_req = 1'b1;
        end
        if (main_bod) begin
            cause   = '{sub: SUB_CLKLOSS, thermal: 1'b0, cls: CLS_MAIN_BOD};
            any_req = 1'b1;
        end
    end

endmodule

// File: rtl/rcc_pulse_seq.sv
module rcc_pulse_seq
    import rcc_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_thermal,
    input  logic tsd_live,
    output logic active
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    seq_e             state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            hold_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_ACTIVE;
                        cnt_q   <= CNT_W'(PULSE_LEN - 1);
                        hold_q  <= start_thermal;
                    end
                end
                default: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!(hold_q && tsd_live)) begin
                        state_q <= SEQ_IDLE;
                        hold_q  <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign active = (state_q == SEQ_ACTIVE);

    AST_THERMAL_HELD: assert property (@(posedge clk) disable iff (rst)
        active && hold_q && tsd_live |=> active); // R6

endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
    import rcc_pkg::*;
#(
    parameter int PULSE_LEN   = 8,
    parameter bit TSD_PRESENT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_rst_i,
    input  logic                main_bod_i,
    input  logic                core_bod_i,
    input  logic                tsd_i,
    input  logic                clk_loss_i,
    input  logic                cpu_rst_req_i,
    input  logic                lockup_i,
    input  logic                wdog_i,
    input  logic                dbg_rst_i,
    input  logic                afsm_tmo_i,
    input  logic                ana_err_i,
    input  logic                dig_err_i,
    input  logic                ctrl_wr_i,
    input  logic [CTRL_W-1:0]   ctrl_wdata_i,
    output logic                sys_rst_o,
    output logic [STATUS_W-1:0] status_o
);

    logic               soft_req;
    logic               tsd_en;
    logic               lfl_arm;
    logic               tsd_live;
    logic               any_req;
    logic               active;
    logic               capture;
    logic [NUM_SYS-1:0] sys_req;
    cause_t             cause;
    cause_t             status_q;

    rcc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_wr_i),
        .wr_data  (ctrl_wdata_i),
        .soft_req (soft_req),
        .tsd_en   (tsd_en),
        .lfl_arm  (lfl_arm)
    );

    assign sys_req = {dig_err_i, ana_err_i, afsm_tmo_i, dbg_rst_i, soft_req,
                      wdog_i, lockup_i, cpu_rst_req_i, clk_loss_i & lfl_arm};

    rcc_arbiter #(.TSD_PRESENT(TSD_PRESENT)) u_arb (
        .main_bod (main_bod_i),
        .core_bod (core_bod_i),
        .pin_req  (pin_rst_i),
        .tsd_raw  (tsd_i),
        .tsd_en   (tsd_en),
        .sys_req  (sys_req),
        .tsd_live (tsd_live),
        .any_req  (any_req),
        .cause    (cause)
    );

    assign capture = any_req & ~active;

    rcc_pulse_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (capture),
        .start_thermal (cause.thermal),
        .tsd_live      (tsd_live),
        .active        (active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= CAUSE_CLEAR;
        end else if (capture) begin
            status_q <= cause;
        end
    end

    assign sys_rst_o = active;
    assign status_o  = status_q;

    // Pulse width monitor for the minimum-width check.
    logic [15:0] wid_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            wid_q <= '0;
        end else if (active) begin
            if (wid_q != '1) wid_q <= wid_q + 1'b1;
        end else begin
            wid_q <= '0;
        end
    end

    AST_LEGAL_CLASS: assert property (@(posedge clk) disable iff (rst)
        status_q.cls inside {CLS_PWRON, CLS_PIN, CLS_MAIN_BOD, CLS_CORE_BOD, CLS_SYSTEM}); // R1
    AST_SUB_ONLY_SYS: assert property (@(posedge clk) disable iff (rst)
        status_q.cls != CLS_SYSTEM |-> status_q.sub == SUB_CLKLOSS); // R2
    AST_MAIN_WINS: assert property (@(posedge clk) disable iff (rst)
        capture && main_bod_i |=> status_q.cls == CLS_MAIN_BOD); // R3
    AST_CLKLOSS_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(active) && status_q.cls == CLS_SYSTEM && status_q.sub == SUB_CLKLOSS
        |-> $past(lfl_arm)); // R5
    AST_THERMAL_IS_PIN: assert property (@(posedge clk) disable iff (rst)
        status_q.thermal |-> status_q.cls == CLS_PIN); // R6
    AST_STATUS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        status_q != $past(status_q) |-> $rose(active)); // R8
    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> wid_q >= 16'(PULSE_LEN)); // R8

endmodule

// File: tb/rst_cause_ctl_tb_top.sv
module rst_cause_ctl_tb_top;

    localparam int PULSE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] src = '0;
    logic        wr  = 1'b0;
    logic [2:0]  wd  = '0;
    logic        rst_o_a, rst_o_b;
    logic [7:0]  st_a, st_b;

    always #4 clk = ~clk;

    // src bit map: 0 pin, 1 main bod, 2 core bod, 3 thermal, 4 clock loss,
    // 5 cpu reset, 6 lockup, 7 watchdog, 8 debug, 9 afsm, 10 ana err, 11 dig err
    rst_cause_ctl #(.PULSE_LEN(PULSE), .TSD_PRESENT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .pin_rst_i(src[0]), .main_bod_i(src[1]),
        .core_bod_i(src[2]), .tsd_i(src[3]), .clk_loss_i(src[4]),
        .cpu_rst_req_i(src[5]), .lockup_i(src[6]), .wdog_i(src[7]),
        .dbg_rst_i(src[8]), .afsm_tmo_i(src[9]), .ana_err_i(src[10]),
        .dig_err_i(src[11]), .ctrl_wr_i(wr), .ctrl_wdata_i(wd),
        .sys_rst_o(rst_o_a), .status_o(st_a)
    );

    rst_cause_ctl #(.PULSE_LEN(PULSE), .TSD_PRESENT(1'b0)) dut_nots_i (
        .clk(clk), .rst(rst), .pin_rst_i(src[0]), .main_bod_i(src[1]),
        .core_bod_i(src[2]), .tsd_i(src[3]), .clk_loss_i(src[4]),
        .cpu_rst_req_i(src[5]), .lockup_i(src[6]), .wdog_i(src[7]),
        .dbg_rst_i(src[8]), .afsm_tmo_i(src[9]), .ana_err_i(src[10]),
        .dig_err_i(src[11]), .ctrl_wr_i(wr), .ctrl_wdata_i(wd),
        .sys_rst_o(rst_o_b), .status_o(st_b)
    );

    typedef struct {
        logic [7:0] st;
        int         len;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    int         vectors  = 0;
    int         miscmp   = 0;
    int         pulses   = 0;
    logic       prev     = 1'b0;
    int         cur_len  = 0;
    logic [7:0] cur_st   = '0;
    logic       nots_seen = 1'b0;
    logic       done     = 1'b0;

    // Monitor: measures each pulse on dut_i and compares with the queue head.
    always @(negedge clk) begin
        if (rst) begin
            prev    = 1'b0;
            cur_len = 0;
        end else begin
            if (rst_o_a) begin
                if (!prev) begin
                    cur_st  = st_a;
                    cur_len = 0;
                    pulses++;
                end
                cur_len++;
            end else if (prev) begin
                vectors++;
                if (exp_q.size() == 0) begin
                    miscmp++;
                    $display("FAIL R10 unexpected pulse: status %h len %0d, expected no pulse",
                             cur_st, cur_len);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (cur_st !== e.st || cur_len != e.len) begin
                        miscmp++;
                        $display("FAIL %s: status %h len %0d, expected status %h len %0d",
                                 e.tag, cur_st, cur_len, e.st, e.len);
                    end
                end
            end
            prev = rst_o_a;
        end
        if (rst_o_b) nots_seen = 1'b1;
    end

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic fire(input logic [11:0] mask, input logic [7:0] st, input int len,
                        input string tag);
        @(negedge clk);
        src = mask;
        exp_q.push_back('{st: st, len: len, tag: tag});
        @(negedge clk);
        src = '0;
        settle();
    endtask

    task automatic write_ctrl(input logic [2:0] d);
        @(negedge clk);
        wr = 1'b1;
        wd = d;
        @(negedge clk);
        wr = 1'b0;
        wd = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_none(input logic [11:0] mask, input logic do_wr,
                               input logic [2:0] d, input string tag);
        int         p;
        logic [7:0] s;
        p = pulses;
        s = st_a;
        @(negedge clk);
        src = mask;
        wr  = do_wr;
        wd  = d;
        @(negedge clk);
        src = '0;
        wr  = 1'b0;
        wd  = '0;
        repeat (15) @(negedge clk);
        vectors++;
        if (pulses != p || st_a !== s || rst_o_a !== 1'b0) begin
            miscmp++;
            $display("FAIL %s: pulses %0d status %h, expected pulses %0d status %h",
                     tag, pulses, st_a, p, s);
        end
    endtask

    task automatic check_clear(input string tag);
        vectors++;
        if (st_a !== 8'h00 || rst_o_a !== 1'b0) begin
            miscmp++;
            $display("FAIL %s: status %h rst %b, expected status 00 rst 0", tag, st_a, rst_o_a);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_clear("R9 reset state");

        // R1 primary classes, R8 pulse length
        fire(12'h001, 8'h01, PULSE, "R1 pin reset");
        fire(12'h002, 8'h02, PULSE, "R1 main brown-out");
        fire(12'h004, 8'h04, PULSE, "R8 core brown-out length");

        // R2 system sub-sources
        fire(12'h020, 8'h16, PULSE, "R2 cpu reset");
        fire(12'h040, 8'h26, PULSE, "R2 lockup");
        fire(12'h080, 8'h36, PULSE, "R2 watchdog");
        fire(12'h100, 8'h56, PULSE, "R2 debug");
        fire(12'h200, 8'h66, PULSE, "R2 afsm timeout");
        fire(12'h400, 8'hE6, PULSE, "R2 analog error");
        fire(12'h800, 8'hF6, PULSE, "R2 digital error");

        // R4 write of zero has no effect
        expect_none(12'h000, 1'b1, 3'b000, "R4 write zero");
        // R5 disarmed clock loss ignored
        expect_none(12'h010, 1'b0, 3'b000, "R5 clock loss disarmed");
        write_ctrl(3'b100);
        fire(12'h010, 8'h06, PULSE, "R5 clock loss armed");

        // R4 software reset (keeps clock-loss armed)
        @(negedge clk);
        wr = 1'b1;
        wd = 3'b101;
        exp_q.push_back('{st: 8'h46, len: PULSE, tag: "R4 software reset"});
        @(negedge clk);
        wr = 1'b0;
        wd = '0;
        settle();

        // R3 priority
        fire(12'h880, 8'hF6, PULSE, "R3 derr over wdog");
        fire(12'h085, 8'h04, PULSE, "R3 core over pin and wdog");
        fire(12'h006, 8'h02, PULSE, "R3 main over core");
        fire(12'h801, 8'h01, PULSE, "R3 pin over derr");

        // R6 thermal disabled
        expect_none(12'h008, 1'b0, 3'b000, "R6 thermal disabled");
        write_ctrl(3'b110);

        // R6 thermal hold, R7 absent sensor
        nots_seen = 1'b0;
        @(negedge clk);
        src[3] = 1'b1;
        exp_q.push_back('{st: 8'h09, len: 20, tag: "R6 thermal hold"});
        repeat (20) @(negedge clk);
        src[3] = 1'b0;
        settle();
        vectors++;
        if (nots_seen !== 1'b0) begin
            miscmp++;
            $display("FAIL R7 absent thermal sensor: reset seen 1, expected 0");
        end
        fire(12'h009, 8'h09, PULSE, "R3 thermal over pin");

        // R10 request during active pulse dropped
        @(negedge clk);
        src = 12'h001;
        exp_q.push_back('{st: 8'h01, len: PULSE, tag: "R10 pin then late derr"});
        @(negedge clk);
        src = '0;
        repeat (2) @(negedge clk);
        src = 12'h800;
        @(negedge clk);
        src = '0;
        settle();
        repeat (10) @(negedge clk);

        // R9 enable bits survive system resets
        fire(12'h010, 8'h06, PULSE, "R9 arm kept after system reset");

        // R9 power-on clears status and enables
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_clear("R9 power-on clears status");
        expect_none(12'h010, 1'b0, 3'b000, "R9 power-on disarms clock loss");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

endmodule